// File: doc/BRIEF.md
# Host Clock Frequency Guard

This block checks the host-domain clock after a watchdog reset or a debug-port reset that happens while the clock controller is in a state where the host domain is enabled. Those resets leave a correctly running host clock alone. The guard then measures that clock against the stable reference clock that it runs on, and tells the clock controller what to do next.

The measurement opens a gate in the reference domain for a fixed number of reference cycles. A counter in the host domain counts host-clock edges while it sees the gate. The count travels back as a Gray code through a two-flop synchronizer, together with an acknowledge level. If the count lies inside the window for 48 MHz ±1%, the guard commands the controller to keep the 96 MHz oscillator, load a divide-by-24 pre-scaler and enter the state where both domains are enabled. If the count lies outside the window, the guard sets a sticky error flag, requests a full controller reset and holds the host-enable grant low. The controller then stays in the core-only state whatever the host-enable request says.

The sequence has five states: IDLE, MEASURE (gate open), DRAIN (gate closed, waiting for the host side to drop its acknowledge), SETTLE (the synchronized count steadies) and DECIDE (the one-cycle verdict). The transitions are:
- IDLE→MEASURE on a qualified reset event.
- MEASURE→DRAIN after the window.
- DRAIN→SETTLE when the acknowledge falls or the drain timeout expires.
- SETTLE→DECIDE after the settle cycles.
- DECIDE→IDLE.

Top module: `hclk_guard`

## Requirements
- R1: A measurement starts, and `busy` goes high on the next reference edge, only when `wdt_rst_evt` or `dbg_rst_evt` is high in IDLE while `host_en_state` is 1. Otherwise `busy` stays 0.
- R2: Reset events that arrive while a measurement runs are ignored, so each accepted trigger yields exactly one `done` pulse.
- R3: Host edges are counted over WIN_CYCLES reference cycles (default 2500, that is 10 µs at a 250 MHz reference). The verdict passes only when the count lies in [LIMIT_LO, LIMIT_HI], which is [475, 485] by default (480 ±1%).
- R4: A stopped host clock gives a fail verdict. If the host acknowledge is not seen during the window, or does not fall within TO_CYCLES after it, the count is taken as zero.
- R5: The host-side counter saturates at 2^CNT_W−1 (4095 by default) and does not wrap, so a clock fast enough to wrap into the window still fails.
- R6: `busy` is 0 after reset. It stays high from the cycle after the trigger through the `done` cycle and is low on the cycle after. `done` lasts one cycle, and `pass` is meaningful only while `done` is high.
- R7: On a pass, `cmd_both_en` and `presc_load` pulse together with `done`, and `presc_val` is 24. `cmd_full_rst` stays low.
- R8: On a fail, `cmd_full_rst` pulses together with `done`, and `err_flag` is 1 from the next cycle. `cmd_both_en` and `presc_load` stay low.
- R9: `err_flag` is 0 after `rst_n`. Once set, it stays set through later measurements, including passing ones, until a cycle with `err_clr` = 1. A fail verdict in the same cycle takes priority over the clear.
- R10: `host_en_grant` follows `host_en_req` while `err_flag` is 0, and is 0 while `err_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Stable reference clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| host_clk | input | 1 | Host-domain clock being measured |
| wdt_rst_evt | input | 1 | Watchdog reset event, one reference cycle |
| dbg_rst_evt | input | 1 | Debug-port reset event, one reference cycle |
| host_en_state | input | 1 | Controller is in a host-enabled state |
| host_en_req | input | 1 | Host-enable request toward the controller |
| err_clr | input | 1 | Write-one-to-clear strobe for the error flag |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | One-cycle verdict strobe |
| pass | output | 1 | Verdict, valid with done |
| err_flag | output | 1 | Sticky frequency error flag |
| host_en_grant | output | 1 | Host-enable request after the error override |
| cmd_both_en | output | 1 | Pulse: keep 96 MHz and enter the both-enabled state |
| presc_load | output | 1 | Pulse: load the pre-scaler |
| presc_val | output | 8 | Pre-scaler divisor to load (24) |
| cmd_full_rst | output | 1 | Pulse: request a full controller reset |

## Verification
The bench drives host clocks just inside and outside the window, from both trigger sources. A design with the limits misplaced or inverted would give the wrong verdict. A stopped host clock is also tested: a design without the timeout would hang in DRAIN or judge a stale count from the previous run.

A clock near 457.6 MHz produces a count that would wrap to about 480. A wrapping counter would pass it where a saturating one fails. Other cases cover:
- a second trigger during a run, which must not produce an extra verdict;
- a trigger while the host domain is disabled, which must not start a run;
- the error flag across a later passing run, where a non-sticky flag would re-enable the host grant.

// File: rtl/hclk_guard_pkg.sv
`timescale 1ns/1ps
package hclk_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_DRAIN,
        ST_SETTLE,
        ST_DECIDE
    } guard_state_e;

    localparam int PRESC_W     = 8;
    localparam int PRESC_DIV24 = 24;

endpackage

// File: rtl/hclk_sync.sv
`timescale 1ns/1ps
module hclk_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hclk_edge_counter.sv
`timescale 1ns/1ps
module hclk_edge_counter #(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             host_clk,
    input  logic             rst_n,
    input  logic             gate,
    output logic [CNT_W-1:0] gray_out,
    output logic             ack_out
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0]       hrst_q;
    logic             hrst_n;
    logic             gate_s;
    logic             gate_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // reset release synchronized to the host clock
    always_ff @(posedge host_clk or negedge rst_n) begin
        if (!rst_n) hrst_q <= 2'b00;
        else        hrst_q <= {hrst_q[0], 1'b1};
    end
    assign hrst_n = hrst_q[1];

    hclk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_gate_sync (
        .clk   (host_clk),
        .rst_n (hrst_n),
        .d     (gate),
        .q     (gate_s)
    );

    // clear on gate rise, count while gate seen, saturate at all ones
    always_comb begin
        cnt_d = cnt_q;
        if (gate_s && !gate_d)                 cnt_d = '0;
        else if (gate_s && cnt_q != CNT_MAX)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge host_clk or negedge hrst_n) begin
        if (!hrst_n) begin
            gate_d   <= 1'b0;
            ack_out  <= 1'b0;
            cnt_q    <= '0;
            gray_out <= '0;
        end else begin
            gate_d   <= gate_s;
            ack_out  <= gate_s;
            cnt_q    <= cnt_d;
            gray_out <= cnt_d ^ (cnt_d >> 1);
        end
    end

    p_sat_r5: assert property (@(posedge host_clk) disable iff (!hrst_n)
        (gate_s && gate_d && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/hclk_verdict_fsm.sv
`timescale 1ns/1ps
module hclk_verdict_fsm
    import hclk_guard_pkg::*;
#(
    parameter int CNT_W         = 12,
    parameter int WIN_CYCLES    = 2500,
    parameter int TO_CYCLES     = 64,
    parameter int SETTLE_CYCLES = 3,
    parameter int LIMIT_LO      = 475,
    parameter int LIMIT_HI      = 485
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_evt,
    input  logic             host_en_state,
    input  logic             ack_s,
    input  logic [CNT_W-1:0] cnt_s,
    output logic             gate,
    output logic             busy,
    output logic             done,
    output logic             pass
);
    localparam int TMR_W = $clog2(WIN_CYCLES + TO_CYCLES + SETTLE_CYCLES + 1);
    localparam logic [TMR_W-1:0] WIN_LAST    = TMR_W'(WIN_CYCLES - 1);
    localparam logic [TMR_W-1:0] TO_LAST     = TMR_W'(TO_CYCLES - 1);
    localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] LO_LIM      = CNT_W'(LIMIT_LO);
    localparam logic [CNT_W-1:0] HI_LIM      = CNT_W'(LIMIT_HI);

    guard_state_e     state_q, state_d;
    logic [TMR_W-1:0] tmr_q;
    logic             ack_seen_q;
    logic             zero_q;
    logic [CNT_W-1:0] cap_q;
    logic             trig;

    assign trig = start_evt && host_en_state;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (trig)                         state_d = ST_MEASURE;
            ST_MEASURE: if (tmr_q == WIN_LAST)            state_d = ST_DRAIN;
            ST_DRAIN:   if (!ack_s || tmr_q == TO_LAST)   state_d = ST_SETTLE;
            ST_SETTLE:  if (tmr_q == SETTLE_LAST)         state_d = ST_DECIDE;
            ST_DECIDE:                                    state_d = ST_IDLE;
            default:                                      state_d = ST_IDLE;
        endcase
    end

    // state register with its timer and capture path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            tmr_q      <= '0;
            ack_seen_q <= 1'b0;
            zero_q     <= 1'b0;
            cap_q      <= '0;
        end else begin
            state_q <= state_d;
            tmr_q   <= (state_d != state_q) ? '0 : tmr_q + 1'b1;
            unique case (state_q)
                ST_IDLE: begin
                    ack_seen_q <= 1'b0;
                    zero_q     <= 1'b0;
                end
                ST_MEASURE: begin
                    if (ack_s) ack_seen_q <= 1'b1;
                    if (tmr_q == WIN_LAST && !(ack_seen_q || ack_s)) zero_q <= 1'b1;
                end
                ST_DRAIN: begin
                    if (ack_s && tmr_q == TO_LAST) zero_q <= 1'b1;
                end
                ST_SETTLE: begin
                    if (tmr_q == SETTLE_LAST) cap_q <= zero_q ? '0 : cnt_s;
                end
                ST_DECIDE: ;
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        gate = (state_q == ST_MEASURE);
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DECIDE);
        pass = done && !zero_q && (cap_q >= LO_LIM) && (cap_q <= HI_LIM);
    end

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && trig) |=> busy);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !trig) |=> !busy);
    p_no_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy && $stable(ack_seen_q) || state_q != ST_MEASURE || busy));
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/hclk_guard.sv
`timescale 1ns/1ps
module hclk_guard
    import hclk_guard_pkg::*;
#(
    parameter int CNT_W         = 12,
    parameter int SYNC_STAGES   = 2,
    parameter int WIN_CYCLES    = 2500,
    parameter int TO_CYCLES     = 64,
    parameter int SETTLE_CYCLES = 3,
    parameter int LIMIT_LO      = 475,
    parameter int LIMIT_HI      = 485
) (
    input  logic               ref_clk,
    input  logic               rst_n,
    input  logic               host_clk,
    input  logic               wdt_rst_evt,
    input  logic               dbg_rst_evt,
    input  logic               host_en_state,
    input  logic               host_en_req,
    input  logic               err_clr,
    output logic               busy,
    output logic               done,
    output logic               pass,
    output logic               err_flag,
    output logic               host_en_grant,
    output logic               cmd_both_en,
    output logic               presc_load,
    output logic [PRESC_W-1:0] presc_val,
    output logic               cmd_full_rst
);
    logic             gate;
    logic             ack_h;
    logic             ack_s;
    logic [CNT_W-1:0] gray_h;
    logic [CNT_W-1:0] gray_s;
    logic [CNT_W-1:0] cnt_bin;

    hclk_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) i_counter (
        .host_clk (host_clk),
        .rst_n    (rst_n),
        .gate     (gate),
        .gray_out (gray_h),
        .ack_out  (ack_h)
    );

    hclk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) i_ack_sync (
        .clk (ref_clk), .rst_n (rst_n), .d (ack_h), .q (ack_s)
    );

    hclk_sync #(.WIDTH(CNT_W), .STAGES(SYNC_STAGES)) i_gray_sync (
        .clk (ref_clk), .rst_n (rst_n), .d (gray_h), .q (gray_s)
    );

    always_comb begin
        cnt_bin[CNT_W-1] = gray_s[CNT_W-1];
        for (int i = CNT_W - 2; i >= 0; i--) begin
            cnt_bin[i] = cnt_bin[i+1] ^ gray_s[i];
        end
    end

    hclk_verdict_fsm #(
        .CNT_W         (CNT_W),
        .WIN_CYCLES    (WIN_CYCLES),
        .TO_CYCLES     (TO_CYCLES),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .LIMIT_LO      (LIMIT_LO),
        .LIMIT_HI      (LIMIT_HI)
    ) i_fsm (
        .clk           (ref_clk),
        .rst_n         (rst_n),
        .start_evt     (wdt_rst_evt || dbg_rst_evt),
        .host_en_state (host_en_state),
        .ack_s         (ack_s),
        .cnt_s         (cnt_bin),
        .gate          (gate),
        .busy          (busy),
        .done          (done),
        .pass          (pass)
    );

    // sticky error flag: a fail beats a same-cycle clear
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n)              err_flag <= 1'b0;
        else if (done && !pass)  err_flag <= 1'b1;
        else if (err_clr)        err_flag <= 1'b0;
    end

    always_comb begin
        host_en_grant = host_en_req && !err_flag;
        cmd_both_en   = done && pass;
        presc_load    = done && pass;
        presc_val     = PRESC_W'(PRESC_DIV24);
        cmd_full_rst  = done && !pass;
    end

    p_fail_flag_r8: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (done && !pass) |=> err_flag);
    p_flag_sticky_r9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

endmodule

// File: tb/test_hclk_guard.sv
`timescale 1ns/1ps
module test_hclk_guard;
    logic       ref_clk = 1'b0;
    logic       host_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_rst_evt = 1'b0, dbg_rst_evt = 1'b0;
    logic       host_en_state = 1'b0, host_en_req = 1'b0, err_clr = 1'b0;
    logic       busy, done, pass, err_flag, host_en_grant;
    logic       cmd_both_en, presc_load, cmd_full_rst;
    logic [7:0] presc_val;

    int  n_checks = 0;
    int  n_fail   = 0;
    real hhalf    = 10.4167;
    bit  host_run = 1'b1;
    bit  exp_q[$];

    hclk_guard i_hclk_guard (
        .ref_clk (ref_clk), .rst_n (rst_n), .host_clk (host_clk),
        .wdt_rst_evt (wdt_rst_evt), .dbg_rst_evt (dbg_rst_evt),
        .host_en_state (host_en_state), .host_en_req (host_en_req),
        .err_clr (err_clr), .busy (busy), .done (done), .pass (pass),
        .err_flag (err_flag), .host_en_grant (host_en_grant),
        .cmd_both_en (cmd_both_en), .presc_load (presc_load),
        .presc_val (presc_val), .cmd_full_rst (cmd_full_rst)
    );

    always #2 ref_clk = ~ref_clk;

    initial forever begin
        #(hhalf);
        if (host_run) host_clk = ~host_clk;
        else          host_clk = 1'b0;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: one expected verdict per accepted trigger
    always @(negedge ref_clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected verdict", 1, 0);
            end else begin
                automatic bit e = exp_q.pop_front();
                check(pass == e, "R3 verdict", int'(pass), int'(e));
                check(cmd_both_en == e && presc_load == e, "R7 both/presc pulse",
                      int'(cmd_both_en), int'(e));
                check(presc_val == 8'd24, "R7 presc value", int'(presc_val), 24);
                check(cmd_full_rst == !e, "R8 full reset pulse", int'(cmd_full_rst), int'(!e));
            end
        end
    end

    task automatic run_meas(input real half, input bit run, input bit use_dbg, input bit exp_pass);
        hhalf    = half;
        host_run = run;
        #300;
        @(negedge ref_clk);
        exp_q.push_back(exp_pass);
        if (use_dbg) dbg_rst_evt = 1'b1; else wdt_rst_evt = 1'b1;
        @(negedge ref_clk);
        wdt_rst_evt = 1'b0; dbg_rst_evt = 1'b0;
        check(busy == 1'b1, "R1 busy after trigger", int'(busy), 1);
        repeat (20) @(negedge ref_clk);
        // R2: second event while running must be ignored
        wdt_rst_evt = 1'b1; dbg_rst_evt = 1'b1;
        @(negedge ref_clk);
        wdt_rst_evt = 1'b0; dbg_rst_evt = 1'b0;
        check(busy == 1'b1, "R6 busy during run", int'(busy), 1);
        while (busy) @(negedge ref_clk);
        repeat (5) @(negedge ref_clk);
        check(busy == 1'b0, "R2 no restart", int'(busy), 0);
    endtask

    initial begin
        #600000;
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        host_en_req = 1'b1;
        repeat (5) @(negedge ref_clk);
        rst_n = 1'b1;
        @(negedge ref_clk);
        check(busy == 0 && done == 0, "R6 reset busy/done", int'(busy), 0);
        check(err_flag == 0, "R9 reset flag", int'(err_flag), 0);
        check(host_en_grant == 1, "R10 grant follows req", int'(host_en_grant), 1);

        // R1: host domain disabled, event ignored
        host_en_state = 1'b0;
        wdt_rst_evt = 1'b1;
        @(negedge ref_clk);
        wdt_rst_evt = 1'b0;
        check(busy == 0, "R1 no start when host disabled", int'(busy), 0);
        repeat (30) @(negedge ref_clk);
        check(busy == 0, "R1 still idle", int'(busy), 0);

        host_en_state = 1'b1;
        run_meas(10.4167, 1, 0, 1);            // R3 48 MHz, watchdog trigger
        check(err_flag == 0, "R8 no flag on pass", int'(err_flag), 0);
        run_meas(10.482, 1, 1, 1);             // R3 47.7 MHz, debug trigger
        run_meas(10.638, 1, 0, 0);             // R3 47 MHz below window
        check(err_flag == 1, "R8 flag after fail", int'(err_flag), 1);
        check(host_en_grant == 0, "R10 grant blocked", int'(host_en_grant), 0);
        run_meas(10.4167, 1, 1, 1);            // passing run, flag must stay
        check(err_flag == 1, "R9 sticky across pass", int'(err_flag), 1);

        err_clr = 1'b1;
        @(negedge ref_clk);
        err_clr = 1'b0;
        check(err_flag == 0, "R9 cleared by write one", int'(err_flag), 0);
        check(host_en_grant == 1, "R10 grant restored", int'(host_en_grant), 1);

        run_meas(10.204, 1, 0, 0);             // R3 49 MHz above window
        run_meas(1.0927, 1, 1, 0);             // R5 wraps to ~480 if not saturating
        check(err_flag == 1, "R5 saturated count fails", int'(err_flag), 1);
        err_clr = 1'b1;
        @(negedge ref_clk);
        err_clr = 1'b0;
        run_meas(10.4167, 0, 0, 0);            // R4 stopped host clock
        check(err_flag == 1, "R4 stopped clock flagged", int'(err_flag), 1);
        err_clr = 1'b1;
        @(negedge ref_clk);
        err_clr = 1'b0;
        run_meas(10.4167, 1, 1, 1);            // recovery after stop
        check(err_flag == 0, "R9 clear held after pass", int'(err_flag), 0);
        check(exp_q.size() == 0, "R2 all verdicts seen", exp_q.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule